// File: doc/BRIEF.md
# Byte-Lane RAM Select Decoder

This block drives the four active-low chip selects of a 32-bit static RAM array that is split into four 8-bit devices. The array sits on a big-endian bus: the byte at offset 0 within a long word travels on the most significant lane (bits 31..24), and the byte at offset 3 travels on the least significant lane (bits 7..0). Each cycle the decoder looks at the transfer size code, the two low address bits, the read/write direction, the RAM region select and the data strobe. From these it decides which devices take part in the cycle.

A write enables only the lanes that carry valid operand bytes. Those lanes start at the address offset and run until the operand ends or the long word ends, whichever comes first. This keeps byte writes, word writes and misaligned long-word writes (which the processor splits into pieces) from changing bytes they do not own. A read enables all four lanes, because the processor takes only the bytes it needs. The selects are registered to the system clock, so each one follows its inputs by one cycle.

Top module: `ramlane_decode`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, all four selects are high (inactive).
- R2: The selects are registered. Inputs sampled at a rising clock edge appear on the selects after that edge and stay until the next edge.
- R3: When the region select is low or the data strobe is high, all four selects are high.
- R4: A read (rdWr=1) in the region with the strobe low drives all four selects low, whatever the size code and offset.
- R5: Size code 01 is a byte. A byte write at offset k drives low only the select for offset k. Bit 3 of laneSelN is offset 0 (data bits 31..24), bit 2 is offset 1 (23..16), bit 1 is offset 2 (15..8) and bit 0 is offset 3 (7..0).
- R6: Size code 10 is a word. A word write enables offsets k and k+1, but never past offset 3. At offset 3 only bit 0 goes low.
- R7: Size code 11 is three bytes. A three-byte write enables offsets k through the smaller of k+2 and 3.
- R8: Size code 00 is a long word. A long write enables offsets k through 3, so an aligned long write drives all four selects low.
- R9: A write never enables a lane for an offset below the address offset, and it always enables the lane at the address offset. This holds through a sequence of interleaved byte writes and misaligned long writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sizeCode | input | 2 | Transfer size code (01 byte, 10 word, 11 three bytes, 00 long) |
| addrLow | input | 2 | Address bits 1:0, the byte offset within the long word |
| rdWr | input | 1 | 1 = read, 0 = write |
| regionSel | input | 1 | High when the cycle targets the RAM region |
| strobeN | input | 1 | Active-low data strobe |
| laneSelN | output | 4 | Active-low lane selects; bit 3 = offset 0 (bits 31..24), bit 0 = offset 3 (bits 7..0) |

## Verification
On every cycle, the assertions check four things: an idle cycle leaves all selects high, a read asserts all lanes, a write always includes its own offset lane, and a write never reaches a lane below its offset. Those properties cannot tell whether a write stops at the correct lane for its size. Only the bench's exhaustive table over size, offset and direction can show the exact end lane of each write, and with it the big-endian lane order. A sequence of byte writes interleaved with misaligned long writes shows that consecutive cycles with different patterns do not leak into each other.

// File: rtl/ramlane_pkg.sv
package ramlane_pkg;
  localparam int LANES = 4;
  localparam int OFFW  = $clog2(LANES);

  typedef struct packed {
    logic             rdAll;
    logic             wrEn;
    logic [OFFW-1:0]  offs;
    logic [OFFW-1:0]  sizeCode;
  } laneCtl_t;
endpackage

// File: rtl/ramlane_ctrl.sv
module ramlane_ctrl
  import ramlane_pkg::*;
(
  input  logic            regionSel,
  input  logic            strobeN,
  input  logic            rdWr,
  input  logic [OFFW-1:0] addrLow,
  input  logic [OFFW-1:0] sizeCode,
  output laneCtl_t        ctl
);
  logic active;

  always_comb begin
    active       = regionSel && !strobeN;
    ctl.rdAll    = active && rdWr;
    ctl.wrEn     = active && !rdWr;
    ctl.offs     = addrLow;
    ctl.sizeCode = sizeCode;
  end
endmodule

// File: rtl/ramlane_dp.sv
module ramlane_dp
  import ramlane_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  laneCtl_t         ctl,
  output logic [LANES-1:0] laneSelN
);
  localparam int SUMW = OFFW + 2;

  logic [SUMW-1:0]  nBytes;
  logic [SUMW-1:0]  endOff;
  logic [LANES-1:0] hitMask;
  logic [LANES-1:0] nextMask;

  always_comb begin
    nBytes = (ctl.sizeCode == '0) ? SUMW'(LANES) : SUMW'(ctl.sizeCode);
    endOff = SUMW'(ctl.offs) + nBytes;
  end

  // Offset g travels on lane bit LANES-1-g (big-endian).
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign hitMask[LANES-1-g] = ctl.wrEn &&
                                (SUMW'(g) >= SUMW'(ctl.offs)) &&
                                (SUMW'(g) < endOff);
  end

  assign nextMask = ctl.rdAll ? '1 : hitMask;

  always_ff @(posedge clk) begin
    if (!rstN) laneSelN <= '1;
    else       laneSelN <= ~nextMask;
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.rdAll || ctl.wrEn) |-> laneSelN == '1); // R3

  AST_READ_ALL: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.rdAll) |-> laneSelN == '0); // R4

  AST_OWN_LANE: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.wrEn) |-> !laneSelN[LANES-1-int'($past(ctl.offs))]); // R9

  AST_NONE_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.wrEn) |->
      ((~laneSelN) & ~({LANES{1'b1}} >> $past(ctl.offs))) == '0); // R9
endmodule

// File: rtl/ramlane_decode.sv
module ramlane_decode
  import ramlane_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       sizeCode,
  input  logic [1:0]       addrLow,
  input  logic             rdWr,
  input  logic             regionSel,
  input  logic             strobeN,
  output logic [3:0]       laneSelN
);
  laneCtl_t ctl;

  ramlane_ctrl u_ctrl (
    .regionSel (regionSel),
    .strobeN   (strobeN),
    .rdWr      (rdWr),
    .addrLow   (addrLow),
    .sizeCode  (sizeCode),
    .ctl       (ctl)
  );

  ramlane_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .laneSelN (laneSelN)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(!rstN) |-> laneSelN == 4'hF); // R1
endmodule

// File: tb/ramlane_decode_bench.sv
module ramlane_decode_bench;
  logic       clk = 0;
  logic       rstN = 0;
  logic [1:0] sizeCode = 0;
  logic [1:0] addrLow = 0;
  logic       rdWr = 1;
  logic       regionSel = 0;
  logic       strobeN = 1;
  logic [3:0] laneSelN;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  typedef struct {
    logic [3:0] exp;
    string      req;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  ramlane_decode u_ramlane_decode (
    .clk(clk), .rstN(rstN), .sizeCode(sizeCode), .addrLow(addrLow),
    .rdWr(rdWr), .regionSel(regionSel), .strobeN(strobeN),
    .laneSelN(laneSelN)
  );

  function automatic logic [3:0] model(input logic [1:0] sz, input logic [1:0] off,
                                       input logic rw, input logic sel, input logic stb);
    logic [3:0] m;
    int n;
    m = 4'hF;
    if (!sel || stb) return m;
    if (rw) return 4'h0;
    n = (sz == 0) ? 4 : int'(sz);
    for (int k = 0; k < 4; k++)
      if (k >= int'(off) && k < int'(off) + n) m[3-k] = 1'b0;
    return m;
  endfunction

  task automatic drive(input logic [1:0] sz, input logic [1:0] off, input logic rw,
                       input logic sel, input logic stb, input string req);
    item_t it;
    @(negedge clk);
    sizeCode = sz; addrLow = off; rdWr = rw; regionSel = sel; strobeN = stb;
    it.exp = model(sz, off, rw, sel, stb);
    it.req = req;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        total++;
        if (laneSelN !== it.exp) begin
          bad++;
          $display("FAIL %s: laneSelN=%b expected=%b", it.req, laneSelN, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!doneFlag) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stimulus
    // R1: selects idle during reset and on the first cycle after it
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (laneSelN !== 4'hF) begin
      bad++;
      $display("FAIL R1: laneSelN=%b expected=1111", laneSelN);
    end
    @(negedge clk);
    rstN = 1;
    @(posedge clk);
    #2;
    total++;
    if (laneSelN !== 4'hF) begin
      bad++;
      $display("FAIL R1: laneSelN=%b expected=1111", laneSelN);
    end

    // R3: outside the region, or strobe inactive
    drive(2'b00, 2'd0, 1'b0, 1'b0, 1'b0, "R3");
    drive(2'b01, 2'd2, 1'b1, 1'b1, 1'b1, "R3");
    drive(2'b00, 2'd0, 1'b0, 1'b1, 1'b1, "R3");

    // R4..R8: exhaustive table over size, offset and direction
    for (int s = 0; s < 4; s++)
      for (int o = 0; o < 4; o++)
        for (int w = 0; w < 2; w++) begin
          string tag;
          if (w == 1)      tag = "R4";
          else if (s == 1) tag = "R5";
          else if (s == 2) tag = "R6";
          else if (s == 3) tag = "R7";
          else             tag = "R8";
          drive(2'(s), 2'(o), 1'(w), 1'b1, 1'b0, tag);
        end

    // R9: byte writes interleaved with misaligned long writes (pieces of each)
    drive(2'b01, 2'd0, 1'b0, 1'b1, 1'b0, "R9");
    drive(2'b00, 2'd1, 1'b0, 1'b1, 1'b0, "R9");
    drive(2'b01, 2'd0, 1'b0, 1'b1, 1'b0, "R9");
    drive(2'b01, 2'd1, 1'b0, 1'b1, 1'b0, "R9");
    drive(2'b00, 2'd2, 1'b0, 1'b1, 1'b0, "R9");
    drive(2'b10, 2'd0, 1'b0, 1'b1, 1'b0, "R9");
    drive(2'b01, 2'd2, 1'b0, 1'b1, 1'b0, "R9");
    drive(2'b00, 2'd3, 1'b0, 1'b1, 1'b0, "R9");
    drive(2'b11, 2'd0, 1'b0, 1'b1, 1'b0, "R9");

    // R2: alternating patterns each cycle, then the output holds while idle
    drive(2'b00, 2'd0, 1'b0, 1'b1, 1'b0, "R2");
    drive(2'b01, 2'd3, 1'b0, 1'b1, 1'b0, "R2");
    drive(2'b00, 2'd0, 1'b1, 1'b1, 1'b0, "R2");
    drive(2'b01, 2'd3, 1'b0, 1'b0, 1'b0, "R2");

    @(negedge clk);
    regionSel = 0; strobeN = 1;
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    doneFlag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule